// File: doc/BRIEF.md
# Address-Type Gate for Inbound Request Headers

This block sits on the receive side of a downstream port and rules on every incoming request header before it goes further. It reads the two-bit address-type field, works out what kind of packet the header describes, and decides whether the packet may continue. A reserved address type, or a non-zero address type on a packet kind that may not carry one, makes the packet malformed. A translation request or a translated access from a requester that has not been granted translated access can be refused with an unsupported-request verdict. Two independent enables control this refusal.

Headers arrive on a valid/ready stream as two dwords. Each accepted header comes out one cycle later with a registered verdict: forward, malformed or unsupported request. The permitted-requester table and the two enable bits are loaded through a small write-only register port. While a register write is in progress the block takes no header, so every lookup sees a consistent table.

Top module: `atype_gate`

## Requirements
- R1: After synchronous reset the verdict-valid output is low, the header-ready output is high, both enables are off and every table entry is invalid.
- R2: A header accepted at a rising clock edge (input valid and ready both high) produces a verdict with verdict-valid high after that same edge. The verdict lasts one cycle and carries the accepted header dwords unchanged. No verdict appears in a cycle with no acceptance.
- R3: The address type is bits 11:10 of header dword 0, encoded 00 untranslated, 01 translation request, 10 translated and 11 reserved. A reserved value always gives verdict code 01 (malformed).
- R4: The packet kind is taken from bits 28:24 of dword 0: 00000 or 00001 is memory, 01100 to 01110 is atomic, and every other value (including I/O 00010, configuration 0010x and message 10xxx) is a non-memory kind. A non-zero address type on a non-memory kind gives verdict 01 (malformed).
- R5: With translation blocking on (control bit 0), a memory or atomic packet with address type 01 or 10 whose requester is not in the table gives verdict code 10 (unsupported request).
- R6: With source validation on (control bit 1), a memory or atomic packet with address type 10 whose requester is not in the table gives verdict 10. Address type 01 is not refused by source validation alone.
- R7: The requester ID is bits 31:16 of header dword 1. A valid table entry that holds that ID lets translated and translation-request memory or atomic packets through with verdict 00 (forward), whatever the enables are.
- R8: The malformed checks take priority over the blocking and validation checks.
- R9: Address type 00 on any packet kind gives verdict 00, whatever the enables and the table hold.
- R10: A register write to address 16+i (bit 4 set, bits 3:0 = i) loads table entry i with ID = data bits 15:0 and valid = data bit 16. The new entry replaces the old one for all later lookups, and writing valid = 0 removes it. Writing address 0 loads the control bits.
- R11: Header-ready is low in any cycle in which a register write is presented, and no header is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Block can take a header |
| in_dw0 | input | 32 | Header dword 0 (kind and address type) |
| in_dw1 | input | 32 | Header dword 1 (requester ID in 31:16) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: 0 control, 16..31 table entries |
| reg_wdata | input | 32 | Register write data |
| v_valid | output | 1 | Verdict present |
| v_code | output | 2 | 00 forward, 01 malformed, 10 unsupported request |
| v_dw0 | output | 32 | Dword 0 of the judged header |
| v_dw1 | output | 32 | Dword 1 of the judged header |

## Verification
The hardest case to reach from the ports is a header and a table write presented in the same cycle. A race there would let a lookup see a half-updated table. The bench raises the write strobe and input valid on the same falling edge. It then checks that no verdict follows and that the new entry governs the next header. The other delicate corners are the overlap of the two enables with the table contents: an unlisted translation request that passes under validation alone but is refused under blocking, and a reserved or misplaced address type that stays malformed even when the requester is also unlisted. Each of these is set up by a directed task that first loads the control bits and the table through the register port.

// File: rtl/atg_pkg.sv
package atg_pkg;
  localparam int AT_HI = 11;
  localparam int AT_LO = 10;

  localparam logic [1:0] AT_UNTR = 2'b00;
  localparam logic [1:0] AT_TREQ = 2'b01;
  localparam logic [1:0] AT_XLAT = 2'b10;
  localparam logic [1:0] AT_RSVD = 2'b11;

  localparam logic [1:0] VD_FWD = 2'b00;
  localparam logic [1:0] VD_MAL = 2'b01;
  localparam logic [1:0] VD_UR  = 2'b10;

  typedef enum logic [2:0] {
    K_MEM, K_ATOM, K_IO, K_CFG, K_MSG, K_OTHER
  } kind_e;
endpackage

// File: rtl/atg_kind_decode.sv
module atg_kind_decode
  import atg_pkg::*;
#(
  parameter int HDR_W = 32
) (
  input  logic [HDR_W-1:0] dw0,
  output kind_e            kind,
  output logic             xlat_ok
);
  logic [4:0] typ;
  assign typ = dw0[28:24];

  always_comb begin
    if (typ[4:3] == 2'b10)                          kind = K_MSG;
    else if (typ == 5'b00000 || typ == 5'b00001)    kind = K_MEM;
    else if (typ == 5'b01100 || typ == 5'b01101 ||
             typ == 5'b01110)                       kind = K_ATOM;
    else if (typ == 5'b00010)                       kind = K_IO;
    else if (typ[4:1] == 4'b0010)                   kind = K_CFG;
    else                                            kind = K_OTHER;
  end

  assign xlat_ok = (kind == K_MEM) || (kind == K_ATOM);
endmodule

// File: rtl/atg_id_table.sv
module atg_id_table #(
  parameter int DEPTH = 16,
  parameter int RID_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RID_W-1:0] wr_id,
  input  logic             wr_vld,
  input  logic [RID_W-1:0] lk_id,
  output logic             hit
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [RID_W-1:0] id_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        id_q  <= '0;
        vld_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        id_q  <= wr_id;
        vld_q <= wr_vld;
      end
    end

    assign match[g] = vld_q && (id_q == lk_id);
  end

  assign hit = |match;
endmodule

// File: rtl/atg_ctrl_regs.sv
module atg_ctrl_regs #(
  parameter int DEPTH  = 16,
  parameter int RID_W  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              blk_en,
  output logic              sv_en,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [RID_W-1:0]  tbl_id,
  output logic              tbl_vld
);
  logic ctrl_sel;

  assign ctrl_sel = reg_wr && (reg_addr == '0);
  assign tbl_we   = reg_wr && reg_addr[AW-1];
  assign tbl_idx  = reg_addr[IDX_W-1:0];
  assign tbl_id   = reg_wdata[RID_W-1:0];
  assign tbl_vld  = reg_wdata[RID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_en <= 1'b0;
      sv_en  <= 1'b0;
    end else if (ctrl_sel) begin
      blk_en <= reg_wdata[0];
      sv_en  <= reg_wdata[1];
    end
  end
endmodule

// File: rtl/atg_judge.sv
module atg_judge
  import atg_pkg::*;
(
  input  logic [1:0] at,
  input  logic       xlat_ok,
  input  logic       hit,
  input  logic       blk_en,
  input  logic       sv_en,
  output logic [1:0] code
);
  always_comb begin
    code = VD_FWD;
    if (at == AT_RSVD)
      code = VD_MAL;
    else if (at != AT_UNTR && !xlat_ok)
      code = VD_MAL;
    else if (at != AT_UNTR && blk_en && !hit)
      code = VD_UR;
    else if (at == AT_XLAT && sv_en && !hit)
      code = VD_UR;
  end
endmodule

// File: rtl/atype_gate.sv
module atype_gate
  import atg_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RID_W   = 16,
  parameter int HDR_W   = 32,
  parameter int DATA_W  = 32,
  parameter int RID_LSB = 16,
  localparam int AW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_dw0,
  input  logic [HDR_W-1:0]  in_dw1,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              v_valid,
  output logic [1:0]        v_code,
  output logic [HDR_W-1:0]  v_dw0,
  output logic [HDR_W-1:0]  v_dw1
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             blk_en, sv_en;
  logic             tbl_we, tbl_vld;
  logic [IDX_W-1:0] tbl_idx;
  logic [RID_W-1:0] tbl_id;
  logic [RID_W-1:0] rid;
  logic             hit, xlat_ok, accept;
  kind_e            kind;
  logic [1:0]       code_d;

  assign in_ready = !reg_wr;
  assign accept   = in_valid && in_ready;
  assign rid      = in_dw1[RID_LSB +: RID_W];

  atg_ctrl_regs #(.DEPTH(DEPTH), .RID_W(RID_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .blk_en(blk_en), .sv_en(sv_en),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_id(tbl_id), .tbl_vld(tbl_vld)
  );

  atg_id_table #(.DEPTH(DEPTH), .RID_W(RID_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_we), .wr_idx(tbl_idx),
    .wr_id(tbl_id), .wr_vld(tbl_vld), .lk_id(rid), .hit(hit)
  );

  atg_kind_decode #(.HDR_W(HDR_W)) u_kind (
    .dw0(in_dw0), .kind(kind), .xlat_ok(xlat_ok)
  );

  atg_judge u_judge (
    .at(in_dw0[AT_HI:AT_LO]), .xlat_ok(xlat_ok), .hit(hit),
    .blk_en(blk_en), .sv_en(sv_en), .code(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_valid <= 1'b0;
      v_code  <= VD_FWD;
      v_dw0   <= '0;
      v_dw1   <= '0;
    end else begin
      v_valid <= accept;
      if (accept) begin
        v_code <= code_d;
        v_dw0  <= in_dw0;
        v_dw1  <= in_dw1;
      end
    end
  end
endmodule

// File: rtl/atype_gate_chk.sv
module atype_gate_chk #(
  parameter int HDR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [HDR_W-1:0] in_dw0,
  input logic             reg_wr,
  input logic             v_valid,
  input logic [1:0]       v_code,
  input logic [HDR_W-1:0] v_dw0
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !v_valid); // R1
  AST_VERDICT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> v_valid); // R2
  AST_NO_SPURIOUS_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !v_valid); // R2
  AST_HEADER_ECHO: assert property (@(posedge clk) disable iff (rst)
    acc |=> v_dw0 == $past(in_dw0)); // R2
  AST_RSVD_MALFORMED: assert property (@(posedge clk) disable iff (rst)
    (acc && in_dw0[11:10] == 2'b11) |=> v_code == 2'b01); // R3
  AST_UNTRANSLATED_FWD: assert property (@(posedge clk) disable iff (rst)
    (acc && in_dw0[11:10] == 2'b00) |=> v_code == 2'b00); // R9
  AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !in_ready); // R11
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> v_code != 2'b11); // R2
endmodule

bind atype_gate atype_gate_chk #(.HDR_W(HDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_dw0(in_dw0), .reg_wr(reg_wr), .v_valid(v_valid),
  .v_code(v_code), .v_dw0(v_dw0)
);

// File: tb/atype_gate_tb.sv
module atype_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dw0 = '0, in_dw1 = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        v_valid;
  logic [1:0]  v_code;
  logic [31:0] v_dw0, v_dw1;
  int          total = 0, bad = 0;

  localparam logic [4:0] T_MEM = 5'b00000, T_IO = 5'b00010, T_CFG = 5'b00100,
                         T_MSG = 5'b10000, T_ATM = 5'b01100, T_CPL = 5'b01010;
  localparam logic [1:0] FWD = 2'b00, MAL = 2'b01, UR = 2'b10;

  always #4 clk = ~clk;

  atype_gate u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dw0(in_dw0), .in_dw1(in_dw1), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .v_valid(v_valid), .v_code(v_code),
    .v_dw0(v_dw0), .v_dw1(v_dw1)
  );

  function automatic logic [31:0] hdr(input logic [2:0] fmt, input logic [4:0] typ,
                                      input logic [1:0] at);
    return {fmt, typ, 12'h0A5, at, 10'h004};
  endfunction

  function automatic logic [31:0] rq(input logic [15:0] id);
    return {id, 16'h00FF};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1 chk("R11", "ready during write", 32'(in_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] d0, input logic [31:0] d1,
                      input logic [1:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_dw0 = d0; in_dw1 = d1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "verdict valid", 32'(v_valid), 1);
    chk(req, "verdict code", 32'(v_code), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1", "v_valid after reset", 32'(v_valid), 0);
    chk("R1", "in_ready after reset", 32'(in_ready), 1);
    send(hdr(3'b000, T_MEM, 2'b10), rq(16'h1234), FWD, "R1");
    wr_reg(5'd0, 32'h1);
    send(hdr(3'b000, T_MEM, 2'b01), rq(16'h0000), UR, "R1");
    wr_reg(5'd0, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d0, d1;
    d0 = hdr(3'b010, T_MEM, 2'b00); d1 = rq(16'hBEEF);
    send(d0, d1, FWD, "R2");
    chk("R2", "dw0 echo", v_dw0, d0);
    chk("R2", "dw1 echo", v_dw1, d1);
    @(negedge clk);
    chk("R2", "single-cycle verdict", 32'(v_valid), 0);
  endtask

  task automatic t_untranslated();
    wr_reg(5'd0, 32'h3);
    send(hdr(3'b000, T_MEM, 2'b00), rq(16'h0BAD), FWD, "R9");
    send(hdr(3'b000, T_IO,  2'b00), rq(16'h0BAD), FWD, "R9");
    send(hdr(3'b000, T_CFG, 2'b00), rq(16'h0BAD), FWD, "R9");
    send(hdr(3'b001, T_MSG, 2'b00), rq(16'h0BAD), FWD, "R9");
    wr_reg(5'd0, 32'h0);
  endtask

  task automatic t_reserved();
    wr_reg(5'd16, 32'h1_0042);
    send(hdr(3'b000, T_MEM, 2'b11), rq(16'h0042), MAL, "R3");
    send(hdr(3'b010, T_ATM, 2'b11), rq(16'h0042), MAL, "R3");
  endtask

  task automatic t_kind();
    send(hdr(3'b000, T_IO,  2'b01), rq(16'h0042), MAL, "R4");
    send(hdr(3'b000, T_CFG, 2'b10), rq(16'h0042), MAL, "R4");
    send(hdr(3'b001, T_MSG, 2'b10), rq(16'h0042), MAL, "R4");
    send(hdr(3'b010, T_CPL, 2'b01), rq(16'h0042), MAL, "R4");
    send(hdr(3'b010, T_ATM, 2'b10), rq(16'h0042), FWD, "R4");
  endtask

  task automatic t_priority();
    wr_reg(5'd0, 32'h3);
    send(hdr(3'b001, T_MSG, 2'b10), rq(16'h7777), MAL, "R8");
    send(hdr(3'b000, T_MEM, 2'b11), rq(16'h7777), MAL, "R8");
    wr_reg(5'd0, 32'h0);
  endtask

  task automatic t_block();
    wr_reg(5'd0, 32'h1);
    send(hdr(3'b000, T_MEM, 2'b01), rq(16'h7777), UR, "R5");
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h7777), UR, "R5");
    send(hdr(3'b010, T_ATM, 2'b01), rq(16'h7777), UR, "R5");
    send(hdr(3'b000, T_MEM, 2'b01), rq(16'h0042), FWD, "R7");
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h0042), FWD, "R7");
    wr_reg(5'd0, 32'h0);
  endtask

  task automatic t_srcval();
    wr_reg(5'd0, 32'h2);
    send(hdr(3'b000, T_MEM, 2'b01), rq(16'h7777), FWD, "R6");
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h7777), UR,  "R6");
    send(hdr(3'b010, T_ATM, 2'b10), rq(16'h0042), FWD, "R7");
    wr_reg(5'd31, 32'h1_9000);
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h9000), FWD, "R7");
  endtask

  task automatic t_table();
    wr_reg(5'd16, 32'h0_0042);
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h0042), UR, "R10");
    wr_reg(5'd31, 32'h1_5555);
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h9000), UR,  "R10");
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h5555), FWD, "R10");
    wr_reg(5'd0, 32'h0);
    send(hdr(3'b010, T_MEM, 2'b10), rq(16'h9000), FWD, "R10");
  endtask

  task automatic t_write_stall();
    wr_reg(5'd0, 32'h2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'd20; reg_wdata = 32'h1_2222;
    in_valid = 1'b1; in_dw0 = hdr(3'b010, T_MEM, 2'b10); in_dw1 = rq(16'h2222);
    #1 chk("R11", "ready low with write", 32'(in_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11", "no verdict during write", 32'(v_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "header taken after write", 32'(v_valid), 1);
    chk("R10", "new entry used", 32'(v_code), 32'(FWD));
    wr_reg(5'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_untranslated();
    t_reserved();
    t_kind();
    t_priority();
    t_block();
    t_srcval();
    t_table();
    t_write_stall();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=20000 cycles expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule